// File: doc/BRIEF.md
# Duty-Cycled Power-Fail Reset Sequencer

This block supervises supply health on the always-on side of a chip. Three digital comparator flags report the supply state: above the power-on level, above the reset level, and below the warning level. The block also sees two reset requests, one from an external pin and one from the watchdog. From these inputs it drives the enables for the core regulator, the crystal oscillator and the power-fail monitor. It also holds the CPU in reset, asserts SRAM retention, and selects the restart address.

When the supply falls under the reset level, the sequencer turns off the regulator and the crystal and keeps SRAM contents. It then wakes the monitor only at a programmed interval, counted in ticks of a slow ring oscillator. The supply must pass a window of two monitored ticks followed by one confirmation tick. Only then does the block start the crystal warmup and release the CPU at the power-fail restart address. A sag that stays above the reset level but below the warning level for long enough raises a sticky warning flag and, if enabled, an interrupt. The CPU keeps running through such a sag.

The whole block runs on one always-running clock `clk`. The ring-oscillator period arrives as a one-cycle strobe, `rosc_tick`. Every comparator and reset-request input passes through a two-flop synchronizer before the state machine uses it.

Top module: `pwr_fail_seq`

## Requirements
- R1: While the synchronized power-on flag is low, all enables and `sram_keep` are 0 and `cpu_rst` is 1.
- R2: On a cold start, the regulator, crystal and monitor are enabled with `cpu_rst` held. Once the supply is above the reset level, `cpu_rst` stays 1 for `XTAL_WARM` cycles of warmup, then drops, and `boot_vec` reads 16'h0000.
- R3: A supply drop below the reset level while running moves the block into the power-fail domain. In that domain `reg_en`=0, `xtal_en`=0, `sram_keep`=1 and `cpu_rst`=1. `mon_sel` is captured only on entry to this domain; later changes have no effect.
- R4: `mon_sel` codes set the interval between monitor windows. Code 1 gives 2^EXP_LO ticks, code 2 gives 2^(EXP_LO+1) ticks and code 3 gives 2^(EXP_LO+2) ticks, with `mon_en`=0 between windows. Code 0 keeps `mon_en`=1 continuously.
- R5: A window enables the monitor for two ticks and then one confirmation tick. If the supply is below the reset level in any cycle of the window, the block returns to waiting, and the interval count restarts from zero.
- R6: After the confirmation tick, `reg_en` and `xtal_en` turn on and `cpu_rst` stays 1 for `XTAL_WARM` cycles. `cpu_rst` then drops with `boot_vec`=16'h8000.
- R7: A pin or watchdog reset holds `cpu_rst` while all three enables stay 1. `cpu_rst` drops on the third clock edge after the request is removed, well under 20 cycles, with `boot_vec`=16'h0000.
- R8: If a supply drop and a pin reset arrive in the same cycle, the power-fail handling wins.
- R9: `warn_flag` is set after `WARN_CYC` consecutive running cycles with the supply above the reset level and below the warning level. Shorter runs leave it 0. The flag stays set until `warn_clr`, and `warn_irq` = `warn_flag` AND `warn_irq_en`.
- R10: A supply dip that is gone before the next clock edge has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | always-running sequencer clock |
| rst_n | input | 1 | active-low reset of the sequencer flops |
| vdd_ge_por | input | 1 | supply above power-on level |
| vdd_ge_rst | input | 1 | supply above reset level |
| vdd_lt_warn | input | 1 | supply below warning level |
| pin_rst | input | 1 | external reset request, active high |
| wdog_rst | input | 1 | watchdog reset request, active high |
| rosc_tick | input | 1 | one-cycle strobe per ring-oscillator period |
| mon_sel | input | 2 | monitor interval code (R4) |
| warn_irq_en | input | 1 | warning interrupt enable |
| warn_clr | input | 1 | clears the warning flag |
| reg_en | output | 1 | core regulator enable |
| xtal_en | output | 1 | crystal oscillator enable |
| mon_en | output | 1 | power-fail monitor enable |
| sram_keep | output | 1 | SRAM retention request |
| cpu_rst | output | 1 | CPU reset hold |
| warn_flag | output | 1 | sticky power-fail warning flag |
| warn_irq | output | 1 | warning interrupt |
| boot_vec | output | ADDR_W | restart address for the CPU |

## Verification
The case to stress is a supply collapse that lands in the same cycle as a pin reset request. Both would move the running state, one toward the reset hold and the other toward the duty-cycled wait. The bench raises both inputs before the same clock edge. It judges the result at the ports: the regulator and monitor must be off with retention on, and the later recovery must restart from 16'h8000. A second overlap arises when a warning sag runs into a full drop. The warning timer is judged on run lengths just below and at the threshold, with random lengths mixed in.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        PS_OFF,
        PS_WARM,
        PS_RUN,
        PS_HOLD,
        PS_WAIT,
        PS_SAMP,
        PS_CONF
    } pwr_state_e;

    typedef struct packed {
        logic reg_en;
        logic xtal_en;
        logic mon_en;
        logic sram_keep;
        logic cpu_hold;
    } pwr_ctl_t;

    function automatic pwr_ctl_t ctl_of(pwr_state_e s, logic cont);
        pwr_ctl_t c;
        c = '0;
        c.cpu_hold = 1'b1;
        case (s)
            PS_WARM, PS_HOLD: begin
                c.reg_en  = 1'b1;
                c.xtal_en = 1'b1;
                c.mon_en  = 1'b1;
            end
            PS_RUN: begin
                c.reg_en   = 1'b1;
                c.xtal_en  = 1'b1;
                c.mon_en   = 1'b1;
                c.cpu_hold = 1'b0;
            end
            PS_WAIT: begin
                c.mon_en    = cont;
                c.sram_keep = 1'b1;
            end
            PS_SAMP, PS_CONF: begin
                c.mon_en    = 1'b1;
                c.sram_keep = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_d, meta_q;
    logic [W-1:0] out_d, out_q;

    always_comb begin
        meta_d = din;
        out_d  = meta_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            out_q  <= '0;
        end else begin
            meta_q <= meta_d;
            out_q  <= out_d;
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/pwrseq_warn.sv
module pwrseq_warn #(
    parameter int WARN_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic running,
    input  logic rst_ok,
    input  logic low_warn,
    input  logic clr,
    input  logic wipe,
    output logic flag
);
    localparam int CW = $clog2(WARN_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } warn_reg_t;

    warn_reg_t q, d;
    logic      sag;

    always_comb begin
        d   = q;
        sag = running && rst_ok && low_warn;
        if (!sag)
            d.cnt = '0;
        else if (q.cnt != CW'(WARN_CYC - 1))
            d.cnt = q.cnt + CW'(1);
        if (wipe)
            d.flag = 1'b0;
        else if (sag && q.cnt == CW'(WARN_CYC - 1))
            d.flag = 1'b1;
        else if (clr)
            d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign flag = q.flag;

    AST_FLAG_NEEDS_SAG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.flag) |-> $past(sag)); // R9
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.flag && !clr && !wipe) |=> q.flag); // R9
endmodule

// File: rtl/pwrseq_core.sv
module pwrseq_core
    import pwrseq_pkg::*;
#(
    parameter int          EXP_LO    = 11,
    parameter int          XTAL_WARM = 64,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] COLD_VEC  = 16'h0000,
    parameter logic [15:0] PF_VEC    = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              rst_ok,
    input  logic              ext_req,
    input  logic              tick,
    input  logic [1:0]        sel,
    output pwr_ctl_t          ctl,
    output logic              running,
    output logic [ADDR_W-1:0] vec
);
    localparam int SPAN = 1 << (EXP_LO + 2);
    localparam int MAXC = (SPAN > XTAL_WARM) ? SPAN : XTAL_WARM;
    localparam int TW   = $clog2(MAXC + 1);

    typedef struct packed {
        pwr_state_e    st;
        logic [TW-1:0] tmr;
        logic [1:0]    mode;
        logic          pf_boot;
    } core_reg_t;

    core_reg_t     q, d;
    logic [TW-1:0] lim;
    logic          in_pf;

    always_comb begin
        case (q.mode)
            2'd1:    lim = TW'(SPAN >> 2);
            2'd2:    lim = TW'(SPAN >> 1);
            default: lim = TW'(SPAN);
        endcase
    end

    always_comb begin
        d = q;
        if (!por_ok) begin
            d.st      = PS_OFF;
            d.tmr     = '0;
            d.pf_boot = 1'b0;
        end else begin
            case (q.st)
                PS_OFF: begin
                    d.st      = PS_WARM;
                    d.tmr     = '0;
                    d.pf_boot = 1'b0;
                end
                PS_WARM: begin
                    if (!rst_ok && q.pf_boot) begin
                        d.st   = PS_WAIT;
                        d.tmr  = '0;
                        d.mode = sel;
                    end else if (q.tmr == TW'(XTAL_WARM - 1)) begin
                        if (rst_ok) d.st = PS_RUN;
                    end else begin
                        d.tmr = q.tmr + TW'(1);
                    end
                end
                PS_RUN, PS_HOLD: begin
                    if (!rst_ok) begin
                        d.st      = PS_WAIT;
                        d.tmr     = '0;
                        d.mode    = sel;
                        d.pf_boot = 1'b1;
                    end else if (ext_req) begin
                        d.st      = PS_HOLD;
                        d.pf_boot = 1'b0;
                    end else begin
                        d.st = PS_RUN;
                    end
                end
                PS_WAIT: begin
                    if (q.mode == 2'd0) begin
                        d.st  = PS_SAMP;
                        d.tmr = '0;
                    end else if (tick) begin
                        if (q.tmr == lim - TW'(1)) begin
                            d.st  = PS_SAMP;
                            d.tmr = '0;
                        end else begin
                            d.tmr = q.tmr + TW'(1);
                        end
                    end
                end
                PS_SAMP: begin
                    if (!rst_ok) begin
                        d.st  = PS_WAIT;
                        d.tmr = '0;
                    end else if (tick) begin
                        if (q.tmr == TW'(1)) begin
                            d.st  = PS_CONF;
                            d.tmr = '0;
                        end else begin
                            d.tmr = q.tmr + TW'(1);
                        end
                    end
                end
                PS_CONF: begin
                    if (!rst_ok) begin
                        d.st  = PS_WAIT;
                        d.tmr = '0;
                    end else if (tick) begin
                        d.st  = PS_WARM;
                        d.tmr = '0;
                    end
                end
                default: d.st = PS_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= PS_OFF;
            q.tmr     <= '0;
            q.mode    <= '0;
            q.pf_boot <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign ctl     = ctl_of(q.st, q.mode == 2'd0);
    assign running = (q.st == PS_RUN);
    assign vec     = q.pf_boot ? ADDR_W'(PF_VEC) : ADDR_W'(COLD_VEC);
    assign in_pf   = (q.st == PS_WAIT) || (q.st == PS_SAMP) || (q.st == PS_CONF);

    AST_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> (ctl.cpu_hold && !ctl.reg_en && !ctl.xtal_en && !ctl.mon_en && !ctl.sram_keep)); // R1
    AST_RELEASE_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl.cpu_hold) |-> $past(rst_ok)); // R2
    AST_PF_DOMAIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (running && por_ok && !rst_ok) |=> (!ctl.reg_en && !ctl.xtal_en && ctl.sram_keep && ctl.cpu_hold)); // R3
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_pf && $past(in_pf)) |-> $stable(q.mode)); // R3
    AST_CONF_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == PS_CONF) |-> ($past(q.st) == PS_SAMP || $past(q.st) == PS_CONF)); // R5
    AST_HOLD_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
        (running && por_ok && rst_ok && ext_req) |=> (ctl.cpu_hold && ctl.reg_en && ctl.xtal_en && ctl.mon_en)); // R7
endmodule

// File: rtl/pwr_fail_seq.sv
module pwr_fail_seq
    import pwrseq_pkg::*;
#(
    parameter int          EXP_LO    = 11,
    parameter int          XTAL_WARM = 64,
    parameter int          WARN_CYC  = 16,
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] COLD_VEC  = 16'h0000,
    parameter logic [15:0] PF_VEC    = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vdd_ge_por,
    input  logic              vdd_ge_rst,
    input  logic              vdd_lt_warn,
    input  logic              pin_rst,
    input  logic              wdog_rst,
    input  logic              rosc_tick,
    input  logic [1:0]        mon_sel,
    input  logic              warn_irq_en,
    input  logic              warn_clr,
    output logic              reg_en,
    output logic              xtal_en,
    output logic              mon_en,
    output logic              sram_keep,
    output logic              cpu_rst,
    output logic              warn_flag,
    output logic              warn_irq,
    output logic [ADDR_W-1:0] boot_vec
);
    localparam int NSYNC = 5;

    logic [NSYNC-1:0] raw_in, syn_in;
    pwr_ctl_t         ctl;
    logic             running;

    assign raw_in = {wdog_rst, pin_rst, vdd_lt_warn, vdd_ge_rst, vdd_ge_por};

    pwrseq_sync #(.W(NSYNC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_in),
        .dout (syn_in)
    );

    pwrseq_core #(
        .EXP_LO   (EXP_LO),
        .XTAL_WARM(XTAL_WARM),
        .ADDR_W   (ADDR_W),
        .COLD_VEC (COLD_VEC),
        .PF_VEC   (PF_VEC)
    ) u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .por_ok (syn_in[0]),
        .rst_ok (syn_in[1]),
        .ext_req(syn_in[3] | syn_in[4]),
        .tick   (rosc_tick),
        .sel    (mon_sel),
        .ctl    (ctl),
        .running(running),
        .vec    (boot_vec)
    );

    pwrseq_warn #(.WARN_CYC(WARN_CYC)) u_warn (
        .clk     (clk),
        .rst_n   (rst_n),
        .running (running),
        .rst_ok  (syn_in[1]),
        .low_warn(syn_in[2]),
        .clr     (warn_clr),
        .wipe    (!syn_in[0]),
        .flag    (warn_flag)
    );

    assign reg_en    = ctl.reg_en;
    assign xtal_en   = ctl.xtal_en;
    assign mon_en    = ctl.mon_en;
    assign sram_keep = ctl.sram_keep;
    assign cpu_rst   = ctl.cpu_hold;
    assign warn_irq  = warn_flag & warn_irq_en;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        warn_irq |-> (warn_flag && warn_irq_en)); // R9
endmodule

// File: tb/sim_pwr_fail_seq.sv
module sim_pwr_fail_seq;
    localparam int CLK_P = 10;
    localparam int EXPL  = 3;
    localparam int XW    = 10;
    localparam int WW    = 8;

    logic clk = 1'b0;
    logic rst_n, vdd_ge_por, vdd_ge_rst, vdd_lt_warn, pin_rst, wdog_rst, rosc_tick;
    logic [1:0] mon_sel;
    logic warn_irq_en, warn_clr;
    logic reg_en, xtal_en, mon_en, sram_keep, cpu_rst, warn_flag, warn_irq;
    logic [15:0] boot_vec;

    int n_chk = 0;
    int n_fail = 0;

    pwr_fail_seq #(.EXP_LO(EXPL), .XTAL_WARM(XW), .WARN_CYC(WW)) u0 (
        .clk(clk), .rst_n(rst_n), .vdd_ge_por(vdd_ge_por), .vdd_ge_rst(vdd_ge_rst),
        .vdd_lt_warn(vdd_lt_warn), .pin_rst(pin_rst), .wdog_rst(wdog_rst),
        .rosc_tick(rosc_tick), .mon_sel(mon_sel), .warn_irq_en(warn_irq_en),
        .warn_clr(warn_clr), .reg_en(reg_en), .xtal_en(xtal_en), .mon_en(mon_en),
        .sram_keep(sram_keep), .cpu_rst(cpu_rst), .warn_flag(warn_flag),
        .warn_irq(warn_irq), .boot_vec(boot_vec)
    );

    always #(CLK_P / 2) clk = ~clk;

    function automatic int span_of(int sel);
        return 1 << (EXPL + sel - 1);
    endfunction

    function automatic logic warn_expect(int len);
        return len >= WW;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick();
        rosc_tick = 1'b1;
        cyc(1);
        rosc_tick = 1'b0;
    endtask

    task automatic measure(output int n);
        int g;
        n = 0;
        g = 0;
        while (mon_en === 1'b0 && g < 5000) begin
            cyc($urandom % 3);
            pulse_tick();
            n++;
            g++;
        end
    endtask

    task automatic wait_mon_low();
        int g;
        g = 0;
        while (mon_en !== 1'b0 && g < 20) begin
            cyc(1);
            g++;
        end
    endtask

    task automatic confirm_and_boot(string req);
        pulse_tick();
        pulse_tick();
        pulse_tick();
        check({req, " warmup enables"}, {reg_en, xtal_en, cpu_rst}, 3'b111);
        cyc(XW - 1);
        check({req, " reset held in warmup"}, cpu_rst, 1'b1);
        cyc(1);
        check({req, " release"}, cpu_rst, 1'b0);
        check({req, " restart vector"}, boot_vec, 16'h8000);
    endtask

    task automatic pf_episode(int sel);
        int n;
        mon_sel = sel[1:0];
        vdd_ge_rst = 1'b0;
        vdd_lt_warn = 1'b1;
        wait_mon_low();
        check("R3 pf domain outputs", {reg_en, xtal_en, sram_keep, cpu_rst}, 4'b0011);
        mon_sel = (sel == 3) ? 2'd1 : 2'(sel + 1);
        measure(n);
        check("R4 interval ticks", n, span_of(sel));
        cyc(1);
        check("R5 low supply aborts window", mon_en, 1'b0);
        vdd_ge_rst = 1'b1;
        vdd_lt_warn = 1'b0;
        cyc(3);
        check("R5 no ticks no window", mon_en, 1'b0);
        measure(n);
        check("R5 interval restarts from zero", n, span_of(sel));
        confirm_and_boot("R6");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 190000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int seed;
        int len;
        logic en;
        seed = $urandom(32'd7421);
        rst_n = 1'b0;
        vdd_ge_por = 1'b0; vdd_ge_rst = 1'b0; vdd_lt_warn = 1'b1;
        pin_rst = 1'b0; wdog_rst = 1'b0; rosc_tick = 1'b0;
        mon_sel = 2'd1; warn_irq_en = 1'b0; warn_clr = 1'b0;
        cyc(3);
        check("R1 reset state", {reg_en, xtal_en, mon_en, sram_keep, cpu_rst}, 5'b00001);
        rst_n = 1'b1;
        cyc(2);
        check("R1 dark below power-on", {reg_en, xtal_en, mon_en, sram_keep, cpu_rst}, 5'b00001);

        // R2 cold start
        vdd_ge_por = 1'b1; vdd_ge_rst = 1'b1; vdd_lt_warn = 1'b0;
        cyc(3);
        check("R2 warmup enables", {reg_en, xtal_en, mon_en, cpu_rst}, 4'b1111);
        cyc(XW - 1);
        check("R2 reset held in warmup", cpu_rst, 1'b1);
        cyc(1);
        check("R2 release", cpu_rst, 1'b0);
        check("R2 cold vector", boot_vec, 16'h0000);

        // R10 dip between edges
        #1 vdd_ge_rst = 1'b0;
        #2 vdd_ge_rst = 1'b1;
        cyc(4);
        check("R10 short dip ignored", {reg_en, xtal_en, mon_en, sram_keep, cpu_rst}, 5'b11100);

        // R9 warning timer, directed edges then random lengths
        for (int i = 0; i < 12; i++) begin
            len = (i == 0) ? WW - 1 : (i == 1) ? WW : 1 + int'($urandom % (2 * WW));
            en = 1'($urandom % 2);
            warn_irq_en = en;
            vdd_lt_warn = 1'b1;
            cyc(len);
            vdd_lt_warn = 1'b0;
            cyc(3);
            check("R9 warning flag", warn_flag, warn_expect(len));
            check("R9 warning irq", warn_irq, warn_expect(len) & en);
            check("R9 cpu keeps running", cpu_rst, 1'b0);
            warn_clr = 1'b1;
            cyc(1);
            warn_clr = 1'b0;
            check("R9 flag cleared", warn_flag, 1'b0);
        end

        // R7 pin and watchdog resets
        pin_rst = 1'b1;
        cyc(3);
        check("R7 pin reset hold", {reg_en, xtal_en, mon_en, cpu_rst}, 4'b1111);
        pin_rst = 1'b0;
        cyc(2);
        check("R7 still held", cpu_rst, 1'b1);
        cyc(1);
        check("R7 pin release timing", cpu_rst, 1'b0);
        check("R7 vector", boot_vec, 16'h0000);
        wdog_rst = 1'b1;
        cyc(3 + int'($urandom % 20));
        check("R7 watchdog hold", {reg_en, xtal_en, mon_en, cpu_rst}, 4'b1111);
        wdog_rst = 1'b0;
        cyc(3);
        check("R7 watchdog release timing", cpu_rst, 1'b0);

        // R3 R4 R5 R6 random intervals
        for (int i = 0; i < 4; i++) begin
            pf_episode((i == 0) ? 3 : 1 + int'($urandom % 3));
        end

        // R4 continuous monitor
        mon_sel = 2'd0;
        vdd_ge_rst = 1'b0; vdd_lt_warn = 1'b1;
        cyc(3);
        begin
            logic ok;
            ok = 1'b1;
            for (int k = 0; k < 16; k++) begin
                if (mon_en !== 1'b1 || reg_en !== 1'b0 || cpu_rst !== 1'b1) ok = 1'b0;
                cyc(1);
            end
            check("R4 code 0 keeps monitor on", ok, 1'b1);
        end
        vdd_ge_rst = 1'b1; vdd_lt_warn = 1'b0;
        cyc(3);
        confirm_and_boot("R4 continuous");

        // R8 supply drop and pin reset in the same cycle
        mon_sel = 2'd1;
        pin_rst = 1'b1; vdd_ge_rst = 1'b0; vdd_lt_warn = 1'b1;
        cyc(3);
        check("R8 power fail wins", {reg_en, mon_en, sram_keep, cpu_rst}, 4'b0011);
        pin_rst = 1'b0;
        vdd_ge_rst = 1'b1; vdd_lt_warn = 1'b0;
        cyc(3);
        begin
            int n;
            measure(n);
            check("R8 interval after overlap", n, span_of(1));
        end
        confirm_and_boot("R8");

        // R1 then R2 after power-on loss
        vdd_ge_por = 1'b0; vdd_ge_rst = 1'b0; vdd_lt_warn = 1'b1;
        cyc(3);
        check("R1 dark after loss", {reg_en, xtal_en, mon_en, sram_keep, cpu_rst}, 5'b00001);
        vdd_ge_por = 1'b1; vdd_ge_rst = 1'b1; vdd_lt_warn = 1'b0;
        cyc(3 + XW - 1);
        check("R2 held after repower", cpu_rst, 1'b1);
        cyc(1);
        check("R2 release after repower", cpu_rst, 1'b0);
        check("R2 vector after repower", boot_vec, 16'h0000);

        finish_run();
    end
endmodule